// File: doc/BRIEF.md
# Video Overlay Transparency Decoder

This block makes one decision per pixel: whether an external video source should show through in place of the generated image. It takes the pixel's colour index as formed from the bitplanes, a flag vector with one key bit per colour register, a flag saying whether the pixel lies inside the active display window, and two control words. The first control word holds the switch that turns on the extended behaviour. The second holds the key and border controls.

With the extended behaviour off, only colour index zero is see-through. With it on, two keys are available and may be used together. The colour key marks any flagged colour register as see-through. The plane key marks a pixel as see-through when one chosen bitplane has its bit set. The area outside the display window can be forced see-through or forced solid. The decision is registered and appears one clock after the pixel index it belongs to.

Top module: `overlay_key`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `show_video` is 0 (solid).
- R2: `show_video` is registered. It reflects the inputs present at the previous rising clock edge and does not change between edges.
- R3: When `base_ctl` bit 0 is 0, `show_video` is 1 exactly when `pix_idx` is 0. `ext_ctl`, `key_flags` and `in_window` have no effect.
- R4: With `base_ctl` bit 0 set and `in_window` 0, `ext_ctl` bit 5 (border see-through) forces `show_video` to 1, whatever the keys.
- R5: With `base_ctl` bit 0 set, `in_window` 0 and `ext_ctl` bit 5 clear, `ext_ctl` bit 4 (border solid) forces `show_video` to 0, whatever the keys.
- R6: With the extended behaviour on and only the colour key enabled (`ext_ctl` bit 10), `show_video` equals `key_flags[pix_idx]`, where bit i of `key_flags` is the key flag (bit 15) of colour register i.
- R7: With the extended behaviour on and only the plane key enabled (`ext_ctl` bit 11), `show_video` equals bit `ext_ctl[14:12]` of `pix_idx`. A selector at or above PLANES never matches.
- R8: With both keys enabled, `show_video` is 1 when either key matches.
- R9: With the extended behaviour on and neither key enabled, `show_video` is 1 exactly when `pix_idx` is 0.
- R10: Inside the display window, `ext_ctl` bits 5 and 4 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_idx | input | PLANES (5) | Colour index; bit i comes from bitplane i |
| key_flags | input | 2**PLANES (32) | Key flag for each colour register |
| in_window | input | 1 | 1 when the pixel is inside the display window |
| base_ctl | input | 16 | Main control word; bit 0 turns on the extended behaviour |
| ext_ctl | input | 16 | Extended control word: [14:12] plane select, 11 plane key, 10 colour key, 5 border see-through, 4 border solid |
| show_video | output | 1 | 1 = external video shows at this pixel |

## Verification
The bench sweeps every colour index against every combination of the extended switch, plane selector, both key enables, both border controls and the window flag, using two contrasting key-flag patterns. The legacy sweep shows whether the extended controls leak through when they are switched off. The border sweeps separate the priority of see-through over solid from the keys underneath. The selectors 5 to 7 check that an out-of-range plane never keys. The two flag patterns separate a colour-key lookup from a plane-key lookup or a zero test. One extra check looks between clock edges to confirm the one-cycle registration.

// File: rtl/overlay_key_pkg.sv
package overlay_key_pkg;

    localparam int CTL_W      = 16;
    localparam int SEL_W      = 3;
    localparam int SEL_LSB    = 12;
    localparam int BIT_ENH    = 0;
    localparam int BIT_PKEY   = 11;
    localparam int BIT_CKEY   = 10;
    localparam int BIT_BBLANK = 5;
    localparam int BIT_BSOLID = 4;

    typedef enum logic [2:0] {
        DEC_LEGACY  = 3'd0,
        DEC_BRD_SEE = 3'd1,
        DEC_BRD_SOL = 3'd2,
        DEC_KEYED   = 3'd3,
        DEC_ZERO    = 3'd4
    } dec_class_t;

    typedef struct packed {
        logic             enh;
        logic [SEL_W-1:0] sel;
        logic             pkey;
        logic             ckey;
        logic             bsee;
        logic             bsol;
    } ctl_fields_t;

endpackage

// File: rtl/overlay_key_mode.sv
module overlay_key_mode
    import overlay_key_pkg::*;
(
    input  logic [CTL_W-1:0] base_ctl,
    input  logic [CTL_W-1:0] ext_ctl,
    input  logic             in_window,
    output ctl_fields_t      fields,
    output dec_class_t       dec
);

    always_comb begin
        fields.enh  = base_ctl[BIT_ENH];
        fields.sel  = ext_ctl[SEL_LSB +: SEL_W];
        fields.pkey = ext_ctl[BIT_PKEY];
        fields.ckey = ext_ctl[BIT_CKEY];
        fields.bsee = ext_ctl[BIT_BBLANK];
        fields.bsol = ext_ctl[BIT_BSOLID];
    end

    always_comb begin
        if (!fields.enh)
            dec = DEC_LEGACY;
        else if (!in_window && fields.bsee)
            dec = DEC_BRD_SEE;
        else if (!in_window && fields.bsol)
            dec = DEC_BRD_SOL;
        else if (fields.pkey || fields.ckey)
            dec = DEC_KEYED;
        else
            dec = DEC_ZERO;
    end

endmodule

// File: rtl/overlay_key_match.sv
module overlay_key_match
    import overlay_key_pkg::*;
#(
    parameter int PLANES = 5
) (
    input  logic [PLANES-1:0]      pix_idx,
    input  logic [(1<<PLANES)-1:0] key_flags,
    input  ctl_fields_t            fields,
    output logic                   key_hit,
    output logic                   is_zero
);

    localparam int SEL_SPAN = 1 << SEL_W;

    logic [SEL_SPAN-1:0] plane_vec;
    logic                plane_hit;
    logic                color_hit;

    for (genvar g = 0; g < SEL_SPAN; g++) begin : g_plane
        if (g < PLANES) begin : g_real
            assign plane_vec[g] = pix_idx[g];
        end else begin : g_absent
            assign plane_vec[g] = 1'b0;
        end
    end

    assign plane_hit = fields.pkey & plane_vec[fields.sel];
    assign color_hit = fields.ckey & key_flags[pix_idx];
    assign key_hit   = plane_hit | color_hit;
    assign is_zero   = (pix_idx == '0);

endmodule

// File: rtl/overlay_key.sv
module overlay_key
    import overlay_key_pkg::*;
#(
    parameter int PLANES = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PLANES-1:0]      pix_idx,
    input  logic [(1<<PLANES)-1:0] key_flags,
    input  logic                   in_window,
    input  logic [CTL_W-1:0]       base_ctl,
    input  logic [CTL_W-1:0]       ext_ctl,
    output logic                   show_video
);

    ctl_fields_t fields;
    dec_class_t  dec;
    logic        key_hit;
    logic        is_zero;
    logic        see_next;

    overlay_key_mode u_mode (
        .base_ctl  (base_ctl),
        .ext_ctl   (ext_ctl),
        .in_window (in_window),
        .fields    (fields),
        .dec       (dec)
    );

    overlay_key_match #(.PLANES(PLANES)) u_match (
        .pix_idx   (pix_idx),
        .key_flags (key_flags),
        .fields    (fields),
        .key_hit   (key_hit),
        .is_zero   (is_zero)
    );

    always_comb begin
        unique case (dec)
            DEC_LEGACY:  see_next = is_zero;
            DEC_BRD_SEE: see_next = 1'b1;
            DEC_BRD_SOL: see_next = 1'b0;
            DEC_KEYED:   see_next = key_hit;
            DEC_ZERO:    see_next = is_zero;
            default:     see_next = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            show_video <= 1'b0;
        else
            show_video <= see_next;
    end

endmodule

// File: rtl/overlay_key_checker.sv
module overlay_key_checker #(
    parameter int PLANES = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [PLANES-1:0]      pix_idx,
    input logic [(1<<PLANES)-1:0] key_flags,
    input logic                   in_window,
    input logic [15:0]            base_ctl,
    input logic [15:0]            ext_ctl,
    input logic                   show_video
);

    assert_reset_solid_R1: assert property (@(posedge clk)
        !rst_n |=> !show_video);

    assert_legacy_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !base_ctl[0] |=> (show_video == ($past(pix_idx) == '0)));

    assert_border_see_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (base_ctl[0] && !in_window && ext_ctl[5]) |=> show_video);

    assert_border_solid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (base_ctl[0] && !in_window && !ext_ctl[5] && ext_ctl[4]) |=> !show_video);

    assert_color_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (base_ctl[0] && in_window && ext_ctl[10] && key_flags[pix_idx]) |=> show_video);

    assert_plane_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (base_ctl[0] && in_window && ext_ctl[11] && (32'(ext_ctl[14:12]) < PLANES)
         && pix_idx[ext_ctl[14:12]]) |=> show_video);

    assert_no_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (base_ctl[0] && in_window && !ext_ctl[11] && !ext_ctl[10]) |=>
        (show_video == ($past(pix_idx) == '0)));

endmodule

bind overlay_key overlay_key_checker #(.PLANES(PLANES)) u_overlay_key_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_idx    (pix_idx),
    .key_flags  (key_flags),
    .in_window  (in_window),
    .base_ctl   (base_ctl),
    .ext_ctl    (ext_ctl),
    .show_video (show_video)
);

// File: tb/overlay_key_test.sv
module overlay_key_test;

    localparam int PLANES = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  pix_idx = '0;
    logic [31:0] key_flags = '0;
    logic        in_window = 1'b0;
    logic [15:0] base_ctl = '0;
    logic [15:0] ext_ctl = '0;
    logic        show_video;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    overlay_key #(.PLANES(PLANES)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_idx    (pix_idx),
        .key_flags  (key_flags),
        .in_window  (in_window),
        .base_ctl   (base_ctl),
        .ext_ctl    (ext_ctl),
        .show_video (show_video)
    );

    function automatic bit model(input bit enh, input int sel, input bit pk, input bit ck,
                                 input bit bsee, input bit bsol, input bit win,
                                 input int pix, input logic [31:0] kf);
        bit ph;
        if (!enh) return (pix == 0);
        if (!win && bsee) return 1'b1;
        if (!win && bsol) return 1'b0;
        if (!pk && !ck) return (pix == 0);
        ph = (sel < PLANES) ? ((pix >> sel) & 1) != 0 : 1'b0;
        return (pk && ph) || (ck && kf[pix]);
    endfunction

    function automatic string tag(input bit enh, input bit pk, input bit ck,
                                  input bit bsee, input bit bsol, input bit win);
        if (!enh) return "R3";
        if (!win && bsee) return "R4";
        if (!win && bsol) return "R5";
        if (win && (bsee || bsol)) return "R10";
        if (pk && ck) return "R8";
        if (ck) return "R6";
        if (pk) return "R7";
        return "R9";
    endfunction

    task automatic check(input string req, input bit act, input bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: show_video=%0b expected=%0b (pix=%0d base=%h ext=%h win=%0b)",
                     req, act, exp, pix_idx, base_ctl, ext_ctl, in_window);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] patterns [2];
        patterns[0] = 32'hA5C3_1E69;
        patterns[1] = 32'h5A3C_E196;

        pix_idx  = 5'd7;
        base_ctl = 16'h0001;
        ext_ctl  = 16'h0C30;
        repeat (3) @(posedge clk);
        #2 check("R1", show_video, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;

        for (int p = 0; p < 2; p++) begin
            key_flags = patterns[p];
            for (int c = 0; c < 256; c++) begin
                for (int pix = 0; pix < 32; pix++) begin
                    bit enh, pk, ck, bsee, bsol, win;
                    int sel;
                    enh  = c[0];
                    sel  = (c >> 1) & 7;
                    pk   = c[4];
                    ck   = c[5];
                    bsee = c[6];
                    bsol = c[7];
                    win  = pix[0] ^ c[3] ^ p[0];
                    @(negedge clk);
                    pix_idx   = 5'(pix);
                    in_window = win;
                    base_ctl  = {15'h7FFE & 15'(pix * 977), enh};
                    ext_ctl   = {1'b0, 3'(sel), pk, ck, 4'(pix), bsee, bsol, 4'(c)};
                    @(posedge clk);
                    #2 check(tag(enh, pk, ck, bsee, bsol, win), show_video,
                             model(enh, sel, pk, ck, bsee, bsol, win, pix, key_flags));
                end
            end
        end

        // R2: output holds between edges, then updates one edge later
        @(negedge clk);
        base_ctl = 16'h0000;
        pix_idx  = 5'd0;
        @(posedge clk);
        #2 check("R2", show_video, 1'b1);
        @(negedge clk);
        pix_idx = 5'd9;
        #1 check("R2", show_video, 1'b1);
        @(posedge clk);
        #2 check("R2", show_video, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule